// File: doc/BRIEF.md
# Serial Port Interrupt Mask and Status Unit

This block gathers the event signals of a serial port (receive trigger level reached, receive queue empty, receive queue full, transmit queue empty, transmit queue full, overrun, framing error, parity error, receive timeout) and turns them into one interrupt line. Software controls which events may interrupt through a mask. The mask cannot be written as a whole word. One write port sets mask bits wherever a 1 is written. A second write port clears mask bits wherever a 1 is written. Both of these locations read back as zero.

An event is recorded in a sticky status word only while its mask bit is set. Software reads the status word, handles the events, and writes the same value back to the acknowledge port. Each 1 clears the matching bit. A raw channel view shows the four queue conditions directly, whether or not they are masked. The five queue conditions are levels, and the unit records each one on its rising edge. The four error and timeout inputs are pulses, and the unit records each one every cycle it is high. The interrupt output is the registered OR of the status word.

Top module: `serial_irq_mask_ctl`

## Requirements
- R1: A cycle with `set_we` high sets every mask bit where `set_data` is 1. All other mask bits keep their value. All 13 mask bits can be set, and the mask reads back at read address 2.
- R2: A cycle with `clr_we` high clears every mask bit where `clr_data` is 1. When `set_we` and `clr_we` both target a bit in the same cycle, the bit ends up cleared.
- R3: Read address 0 (enable port) and read address 1 (disable port) return zero. Addresses 5 to 7 also return zero.
- R4: A status bit can become set only in a cycle when its mask bit was already set. A masked event leaves the status word (read address 3) unchanged.
- R5: A cycle with `ack_we` high clears every status bit where `ack_data` is 1. Bits written with 0, and every bit in cycles without `ack_we`, keep their value.
- R6: If an unmasked event and an acknowledge of the same status bit fall in the same cycle, the bit stays set.
- R7: Event bits 0 to 4 (receive trigger, receive empty, receive full, transmit empty, transmit full) are levels and set their status bit only on a 0-to-1 change. Clearing the bit while the level stays high does not set it again.
- R8: Event bits 5 to 8 (overrun, framing, parity, timeout) are pulses and set their status bit in every cycle they are high.
- R9: Read address 4 returns the raw inputs for receive trigger (bit 0), receive empty (bit 1), transmit empty (bit 3) and transmit full (bit 4), regardless of the mask. All other bits of that word read zero.
- R10: `irq` equals the OR of the status word as it was one clock earlier.
- R11: After reset, the mask, the status word and `irq` are all zero.
- R12: Status bits 9 to 12 have no event source and always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_we | input | 1 | Strobe for the mask-set port |
| set_data | input | 13 | Ones select mask bits to set |
| clr_we | input | 1 | Strobe for the mask-clear port |
| clr_data | input | 13 | Ones select mask bits to clear |
| ack_we | input | 1 | Strobe for the status acknowledge port |
| ack_data | input | 13 | Ones select status bits to clear |
| evt_in | input | 9 | Raw event levels and pulses, bit order as in R7 and R8 |
| rd_addr | input | 3 | Read select: 0 set port, 1 clear port, 2 mask, 3 status, 4 channel view |
| rdata | output | 13 | Combinational read data for `rd_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench aims at the collisions. It drives a set and a clear of the same bit in one cycle; a design that let set win would leave the mask bit on. It drives an event together with an acknowledge of the same bit; a design that let the acknowledge win would lose an interrupt. It holds a level high across an acknowledge; a design that sampled levels instead of edges would reassert the bit at once. It also holds a pulse input high across an acknowledge, which must keep refiring, so a design that edge-detected every input fails there. It also raises events while their mask bits are off and then reads status, and it counts the single cycle of lag on `irq`.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  parameter int unsigned EVT_W  = 9;
  parameter int unsigned MASK_W = 13;
  parameter int unsigned ADDR_W = 3;

  typedef logic [MASK_W-1:0] word_t;
  typedef logic [EVT_W-1:0]  evt_t;

  typedef enum logic [ADDR_W-1:0] {
    SEL_ENABLE  = 3'd0,
    SEL_DISABLE = 3'd1,
    SEL_MASK    = 3'd2,
    SEL_STATUS  = 3'd3,
    SEL_CHAN    = 3'd4
  } sel_e;

  // clear is applied after set, so a clear of the same bit wins
  function automatic word_t mask_next(word_t cur, logic s_we, word_t s,
                                      logic c_we, word_t c);
    word_t v;
    v = cur;
    if (s_we) v = v | s;
    if (c_we) v = v & ~c;
    return v;
  endfunction

  // acknowledge is applied first, so a fresh hit survives it
  function automatic word_t status_next(word_t cur, logic a_we, word_t a,
                                        word_t hit);
    word_t v;
    v = cur;
    if (a_we) v = v & ~a;
    return v | hit;
  endfunction

  function automatic word_t widen(evt_t e);
    return word_t'(e);
  endfunction
endpackage

// File: rtl/sirq_evt_cond.sv
module sirq_evt_cond
  import sirq_pkg::*;
#(
  parameter evt_t LEVEL_BITS = 9'h01F
) (
  input  logic clk,
  input  logic rst_n,
  input  evt_t raw,
  output evt_t fire
);
  for (genvar g = 0; g < EVT_W; g++) begin : g_bit
    if (LEVEL_BITS[g]) begin : g_level
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= raw[g];
      end
      assign fire[g] = raw[g] & ~prev_q;
    end else begin : g_pulse
      assign fire[g] = raw[g];
    end
  end
endmodule

// File: rtl/sirq_mask_reg.sv
module sirq_mask_reg
  import sirq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_we,
  input  word_t set_data,
  input  logic  clr_we,
  input  word_t clr_data,
  output word_t mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_next(mask_q, set_we, set_data, clr_we, clr_data);
  end
endmodule

// File: rtl/sirq_status_reg.sv
module sirq_status_reg
  import sirq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t hit,
  input  logic  ack_we,
  input  word_t ack_data,
  output word_t status_q,
  output logic  irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= status_next(status_q, ack_we, ack_data, hit);
      irq      <= |status_q;
    end
  end
endmodule

// File: rtl/serial_irq_mask_ctl.sv
module serial_irq_mask_ctl
  import sirq_pkg::*;
#(
  parameter evt_t LEVEL_BITS = 9'h01F,
  parameter evt_t CHAN_BITS  = 9'h01B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic [MASK_W-1:0] set_data,
  input  logic              clr_we,
  input  logic [MASK_W-1:0] clr_data,
  input  logic              ack_we,
  input  logic [MASK_W-1:0] ack_data,
  input  logic [EVT_W-1:0]  evt_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [MASK_W-1:0] rdata,
  output logic              irq
);
  evt_t  evt_fire;
  word_t evt_hit;
  word_t mask_q;
  word_t status_q;
  word_t chan_view;

  sirq_evt_cond #(.LEVEL_BITS(LEVEL_BITS)) u_cond (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (evt_in),
    .fire (evt_fire)
  );

  sirq_mask_reg u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_we  (set_we),
    .set_data(set_data),
    .clr_we  (clr_we),
    .clr_data(clr_data),
    .mask_q  (mask_q)
  );

  // only events whose mask bit is already set reach the status word
  assign evt_hit = widen(evt_fire) & mask_q;

  sirq_status_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (evt_hit),
    .ack_we  (ack_we),
    .ack_data(ack_data),
    .status_q(status_q),
    .irq     (irq)
  );

  assign chan_view = widen(evt_in & CHAN_BITS);

  always_comb begin
    case (sel_e'(rd_addr))
      SEL_MASK:   rdata = mask_q;
      SEL_STATUS: rdata = status_q;
      SEL_CHAN:   rdata = chan_view;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker
  import sirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              set_we,
  input logic [MASK_W-1:0] set_data,
  input logic              clr_we,
  input logic [MASK_W-1:0] clr_data,
  input logic              ack_we,
  input logic [MASK_W-1:0] ack_data,
  input logic [MASK_W-1:0] evt_hit,
  input logic [MASK_W-1:0] mask_q,
  input logic [MASK_W-1:0] status_q,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [MASK_W-1:0] rdata,
  input logic              irq
);
  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((mask_q & $past(set_data)) == $past(set_data))); // R1

  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((mask_q & $past(clr_data)) == '0)); // R2

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == SEL_ENABLE || rd_addr == SEL_DISABLE) |-> (rdata == '0)); // R3

  AST_MASKED_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(mask_q)) == '0)); // R4

  AST_UNACKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_we |=> (($past(status_q) & ~status_q) == '0)); // R5

  AST_ACK_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> (($past(status_q) & ~$past(ack_data) & ~status_q) == '0)); // R5

  AST_EVENT_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_hit) |=> ((status_q & $past(evt_hit)) == $past(evt_hit))); // R6

  AST_IRQ_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|status_q)); // R10

  AST_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[MASK_W-1:EVT_W] == '0); // R12
endmodule

bind serial_irq_mask_ctl sirq_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .set_we  (set_we),
  .set_data(set_data),
  .clr_we  (clr_we),
  .clr_data(clr_data),
  .ack_we  (ack_we),
  .ack_data(ack_data),
  .evt_hit (evt_hit),
  .mask_q  (mask_q),
  .status_q(status_q),
  .rd_addr (rd_addr),
  .rdata   (rdata),
  .irq     (irq)
);

// File: tb/sim_serial_irq_mask_ctl.sv
module sim_serial_irq_mask_ctl;
  localparam int PERIOD = 10;
  localparam logic [8:0] LVL = 9'h01F;
  localparam logic [8:0] CHV = 9'h01B;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        set_we, clr_we, ack_we;
  logic [12:0] set_data, clr_data, ack_data;
  logic [8:0]  evt_in;
  logic [2:0]  rd_addr;
  logic [12:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [12:0] m_mask, m_stat;
  logic [8:0]  m_prev;
  logic        m_irq;

  serial_irq_mask_ctl u0 (
    .clk(clk), .rst_n(rst_n),
    .set_we(set_we), .set_data(set_data),
    .clr_we(clr_we), .clr_data(clr_data),
    .ack_we(ack_we), .ack_data(ack_data),
    .evt_in(evt_in), .rd_addr(rd_addr),
    .rdata(rdata), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [12:0] model_read(input logic [2:0] a);
    case (a)
      3'd2:    return m_mask;
      3'd3:    return m_stat;
      3'd4:    return {4'b0, evt_in & CHV};
      default: return 13'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd2:    return "R1";
      3'd3:    return "R4";
      3'd4:    return "R9";
      default: return "R3";
    endcase
  endfunction

  task automatic cyc(input logic sw, input logic [12:0] sd,
                     input logic cw, input logic [12:0] cd,
                     input logic aw, input logic [12:0] ad,
                     input logic [8:0] ev);
    logic [12:0] nm, ns;
    @(negedge clk);
    set_we = sw; set_data = sd;
    clr_we = cw; clr_data = cd;
    ack_we = aw; ack_data = ad;
    evt_in = ev;
    for (int k = 0; k < 13; k++) begin
      logic f;
      f = 1'b0;
      if (k < 9) f = ev[k] && (!LVL[k] || !m_prev[k]);
      ns[k] = (m_stat[k] && !(aw && ad[k])) || (f && m_mask[k]);
      if (cw && cd[k])      nm[k] = 1'b0;
      else if (sw && sd[k]) nm[k] = 1'b1;
      else                  nm[k] = m_mask[k];
    end
    m_irq  = |m_stat;
    m_stat = ns;
    m_mask = nm;
    m_prev = ev;
  endtask

  task automatic settle();
    @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic look(input logic [2:0] a, input string tag);
    logic [12:0] e;
    rd_addr = a;
    #1;
    e = model_read(a);
    checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s addr %0d rdata %h expected %h", tag, a, rdata, e);
    end
  endtask

  task automatic look_irq(input string tag);
    checks++;
    if (irq !== m_irq) begin
      errors++;
      $display("FAIL %s irq %b expected %b", tag, irq, m_irq);
    end
  endtask

  task automatic idle(input logic [8:0] ev);
    cyc(0, 13'h0, 0, 13'h0, 0, 13'h0, ev);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] lv;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    set_we = 0; clr_we = 0; ack_we = 0;
    set_data = 0; clr_data = 0; ack_data = 0;
    evt_in = 0; rd_addr = 0;
    m_mask = 0; m_stat = 0; m_prev = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    idle(9'h0); settle();
    look(3'd2, "R11"); look(3'd3, "R11"); look_irq("R11");

    // R1 and R12: set wide pattern incl. bits 9..12, then add one bit
    cyc(1, 13'h1E05, 0, 13'h0, 0, 13'h0, 9'h0); settle(); look(3'd2, "R1");
    cyc(1, 13'h0002, 0, 13'h0, 0, 13'h0, 9'h0); settle(); look(3'd2, "R1");

    // R3: write-only ports and unmapped addresses read zero
    look(3'd0, "R3"); look(3'd1, "R3"); look(3'd7, "R3");

    // R2: same-cycle set and clear, clear wins
    cyc(1, 13'h00F0, 1, 13'h0030, 0, 13'h0, 9'h0); settle(); look(3'd2, "R2");
    cyc(0, 13'h0, 1, 13'h1E00, 0, 13'h0, 9'h0); settle(); look(3'd2, "R2");

    // R4 and R8: parity pulse unmasked, overrun masked
    cyc(0, 13'h0, 0, 13'h0, 0, 13'h0, 9'h0A0); settle();
    look(3'd3, "R4"); look_irq("R10");
    idle(9'h0); settle(); look_irq("R10");

    // R5: ack an unset bit, then the set one
    cyc(0, 13'h0, 0, 13'h0, 1, 13'h0020, 9'h0); settle(); look(3'd3, "R5");
    cyc(0, 13'h0, 0, 13'h0, 1, 13'h0080, 9'h0); settle(); look(3'd3, "R5");

    // R6: framing pulse and its acknowledge in the same cycle
    cyc(0, 13'h0, 0, 13'h0, 1, 13'h0040, 9'h040); settle(); look(3'd3, "R6");
    cyc(0, 13'h0, 0, 13'h0, 1, 13'h0040, 9'h0); settle(); look(3'd3, "R6");

    // R7: transmit-empty level held across an acknowledge
    cyc(1, 13'h0008, 0, 13'h0, 0, 13'h0, 9'h0); settle();
    idle(9'h008); settle(); look(3'd3, "R7");
    cyc(0, 13'h0, 0, 13'h0, 1, 13'h0008, 9'h008); settle(); look(3'd3, "R7");
    idle(9'h008); idle(9'h008); settle(); look(3'd3, "R7");
    idle(9'h000); idle(9'h008); settle(); look(3'd3, "R7");
    cyc(0, 13'h0, 0, 13'h0, 1, 13'h0008, 9'h000); settle(); look(3'd3, "R7");

    // R8: timeout held high keeps refiring through an acknowledge
    cyc(1, 13'h0100, 0, 13'h0, 0, 13'h0, 9'h0); settle();
    idle(9'h100); settle(); look(3'd3, "R8");
    cyc(0, 13'h0, 0, 13'h0, 1, 13'h0100, 9'h100); settle(); look(3'd3, "R8");
    cyc(0, 13'h0, 0, 13'h0, 1, 13'h0100, 9'h000); settle(); look(3'd3, "R8");

    // R9: raw channel view with everything masked
    cyc(0, 13'h0, 1, 13'h1FFF, 1, 13'h1FFF, 9'h000); settle();
    idle(9'h1FF); settle(); look(3'd4, "R9"); look(3'd3, "R4");
    idle(9'h012); settle(); look(3'd4, "R9");

    // random phase
    lv = 9'h0;
    for (int i = 0; i < 4000; i++) begin
      logic [8:0] ev;
      logic [12:0] ad;
      for (int b = 0; b < 5; b++) if ($urandom % 8 == 0) lv[b] = ~lv[b];
      ev = lv;
      for (int b = 5; b < 9; b++) ev[b] = ($urandom % 6 == 0);
      ad = ($urandom % 2 == 0) ? m_stat : 13'($urandom);
      cyc($urandom % 4 == 0, 13'($urandom),
          $urandom % 5 == 0, 13'($urandom),
          $urandom % 3 == 0, ad, ev);
      settle();
      begin
        logic [2:0] a;
        a = 3'($urandom);
        look(a, tag_of(a));
      end
      look_irq("R10");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule